// File: doc/BRIEF.md
# Sideband Port Mode Discovery Sequencer

This block is the host-side controller for one downstream two-wire sideband port. It works out whether the port should stay on SMBus or move to I3C Basic. It never touches the clock or data lines itself. It asks a lower-level bus engine for abstract transactions, either a broadcast common command or a single address probe, and reads back the acknowledge result. Around those transactions it drives the pull-up selection, the IO voltage selection, the mode flag and a clock-hold or dedicated reset line that returns targets to SMBus.

A detection pass starts with a hot-join disable broadcast on the reserved address. After that it scans for legacy SMBus-only devices, either through the ARP address or through a configured list of static addresses. The port moves to I3C only if the broadcast was acknowledged and no legacy-only device answered. The move is a second disable broadcast, a swap of pull-ups and voltage, a settling wait, and a hot-join enable broadcast. A hot-plug event or a redo request starts a fresh pass. If the port is already in I3C, the pass first forces the targets back to SMBus. Each port has its own instance.

Top module: `sbmode_seq`

## Requirements
- R1: After reset, mode_i3c, pullup_i3c, vio_low, bus_hold_low, port_rst, req_valid and done are all low. This means SMBus mode, SMBus pull-ups and the 3.3 V rail.
- R2: A pulse on redo_req or hotplug while idle starts a pass. If the port is in SMBus mode, the first request is a broadcast command (req_kind 0) to wire address 0xFC (the reserved address 0x7E with the write bit), command code 0x01 (hot-join disable), events byte 0x08 (bit 3, hot-join).
- R3: req_valid stays high, with kind, address, command and data stable, until req_ready is high at a clock edge. A response (rsp_valid with rsp_ack) is accepted in any of the cfg_timeout cycles that follow that edge. If no response arrives by the end of that window, the request counts as a NACK.
- R4: If the first broadcast is NACKed, the legacy scan still runs. The pass then ends in SMBus mode with no further broadcast.
- R5: The scan uses address probes (req_kind 1, command and data 0x00). With cfg_use_arp high, it makes one probe at 0xC2. Otherwise it probes the static list in index order, with entry i at cfg_static_addr[8i+7:8i], and stops at the first ACK.
- R6: If any scan probe is ACKed, the pass ends at once in SMBus mode, and the pull-up, voltage and mode outputs do not change.
- R7: If the first broadcast was ACKed and no probe is ACKed, a second hot-join disable broadcast is issued. When it completes, pullup_i3c and vio_low rise together and mode_i3c is still low.
- R8: mode_i3c rises exactly max(cfg_tsmb2i3c,1) cycles after pullup_i3c. A broadcast with command code 0x00 (hot-join enable) and events byte 0x08 then follows. mode_i3c high always implies pullup_i3c and vio_low high.
- R9: A pass started in I3C mode first asserts bus_hold_low (cfg_rst_pin low) or port_rst (cfg_rst_pin high) for exactly max(cfg_t2wrst,1) cycles, with no request during that time. In the cycle the hold ends, pullup_i3c, vio_low and mode_i3c all fall, and detection restarts with the R2 broadcast.
- R10: redo_req and hotplug pulses are ignored while a pass is running: the request sequence and the outcome are unchanged.
- R11: done is a one-cycle pulse, one per pass, given after the final response of the pass while no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redo_req | input | 1 | Request a new detection pass |
| hotplug | input | 1 | Hot-plug event, starts a new pass |
| cfg_use_arp | input | 1 | Scan via the ARP address instead of the static list |
| cfg_rst_pin | input | 1 | Use port_rst rather than clock hold to return to SMBus |
| cfg_t2wrst | input | CW | Hold time for the return to SMBus, in cycles |
| cfg_tsmb2i3c | input | CW | Settle time before I3C signalling, in cycles |
| cfg_timeout | input | CW | Response window per request, in cycles |
| cfg_static_addr | input | NSTAT*8 | Static probe list, wire-format addresses |
| req_valid | output | 1 | Request to bus engine is valid |
| req_ready | input | 1 | Bus engine accepts the request |
| req_kind | output | 1 | 0 broadcast command, 1 address probe |
| req_addr | output | 8 | Wire-format target address |
| req_ccc | output | 8 | Broadcast command code |
| req_data | output | 8 | Command events byte |
| rsp_valid | input | 1 | Bus engine response valid |
| rsp_ack | input | 1 | Response was acknowledged |
| bus_hold_low | output | 1 | Ask the engine to hold the clock line low |
| port_rst | output | 1 | Dedicated reset to the port targets |
| mode_i3c | output | 1 | Port runs I3C Basic |
| pullup_i3c | output | 1 | I3C pull-ups selected (SMBus pull-ups when low) |
| vio_low | output | 1 | 1.8 V IO selected (3.3 V when low) |
| done | output | 1 | Pass complete pulse |

## Verification
The hardest case to reach from the ports is the return from I3C to SMBus. That path needs a full promotion pass first, then a hot-plug pulse, and only then can the hold length and the same-cycle drop of the rails be observed. The bench chains passes so that each one starts from the state the previous one left. A scripted bus-engine model sets acknowledge, delay and silence per pass, which drives the timeout window to its last accepted cycle and past it. Pulses injected mid-scan exercise the ignore rule.

// File: rtl/sbmode_pkg.sv
package sbmode_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_PROBE,
        ST_DISC,
        ST_SWITCH,
        ST_SETTLE,
        ST_ENABLE
    } seq_state_e;

    typedef enum logic {
        KIND_CCC   = 1'b0,
        KIND_PROBE = 1'b1
    } req_kind_e;

    typedef struct packed {
        req_kind_e  kind;
        logic [7:0] addr;
        logic [7:0] ccc;
        logic [7:0] data;
    } bus_req_t;

    localparam logic [7:0] BCAST_WADDR = 8'hFC;
    localparam logic [7:0] ARP_WADDR   = 8'hC2;
    localparam logic [7:0] CCC_HJ_OFF  = 8'h01;
    localparam logic [7:0] CCC_HJ_ON   = 8'h00;
    localparam logic [7:0] HJ_EVENT    = 8'h08;

    function automatic bus_req_t mk_ccc(input logic [7:0] code);
        bus_req_t r;
        r.kind = KIND_CCC;
        r.addr = BCAST_WADDR;
        r.ccc  = code;
        r.data = HJ_EVENT;
        return r;
    endfunction

    function automatic bus_req_t mk_probe(input logic [7:0] a);
        bus_req_t r;
        r.kind = KIND_PROBE;
        r.addr = a;
        r.ccc  = 8'h00;
        r.data = 8'h00;
        return r;
    endfunction

endpackage

// File: rtl/sbmode_timer.sv
module sbmode_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // a loaded value N gives an interval of max(N,1) cycles
    assign expired = (cnt <= CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (!expired) begin
            cnt <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/sbmode_xact.sv
module sbmode_xact #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [CW-1:0] timeout,
    output logic          req_valid,
    input  logic          req_ready,
    input  logic          rsp_valid,
    input  logic          rsp_ack,
    output logic          fin,
    output logic          fin_ack
);
    typedef enum logic [1:0] {X_IDLE, X_REQ, X_WAIT} xact_state_e;

    xact_state_e   st;
    logic [CW:0]   wcnt;
    logic [CW:0]   wnext;

    assign req_valid = (st == X_REQ);
    assign wnext     = wcnt + {{CW{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= X_IDLE;
            wcnt    <= '0;
            fin     <= 1'b0;
            fin_ack <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (st)
                X_IDLE: if (go) st <= X_REQ;
                X_REQ: if (req_ready) begin
                    st   <= X_WAIT;
                    wcnt <= '0;
                end
                X_WAIT: begin
                    if (rsp_valid) begin
                        fin     <= 1'b1;
                        fin_ack <= rsp_ack;
                        st      <= X_IDLE;
                    end else if (wnext >= {1'b0, timeout}) begin
                        fin     <= 1'b1;
                        fin_ack <= 1'b0;
                        st      <= X_IDLE;
                    end else begin
                        wcnt <= wnext;
                    end
                end
                default: st <= X_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sbmode_scan.sv
module sbmode_scan
    import sbmode_pkg::*;
#(
    parameter int NSTAT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               adv,
    input  logic               use_arp,
    input  logic [NSTAT*8-1:0] list,
    output logic [7:0]         addr,
    output logic               last
);
    localparam int IW = (NSTAT > 1) ? $clog2(NSTAT) : 1;

    logic [7:0]    tbl [NSTAT];
    logic [IW-1:0] idx;

    for (genvar g = 0; g < NSTAT; g++) begin : g_tbl
        assign tbl[g] = list[g*8 +: 8];
    end

    assign addr = use_arp ? ARP_WADDR : tbl[idx];
    assign last = use_arp || (idx == IW'(NSTAT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (adv) begin
            idx <= idx + IW'(1);
        end
    end
endmodule

// File: rtl/sbmode_seq.sv
module sbmode_seq
    import sbmode_pkg::*;
#(
    parameter int CW    = 16,
    parameter int NSTAT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               redo_req,
    input  logic               hotplug,
    input  logic               cfg_use_arp,
    input  logic               cfg_rst_pin,
    input  logic [CW-1:0]      cfg_t2wrst,
    input  logic [CW-1:0]      cfg_tsmb2i3c,
    input  logic [CW-1:0]      cfg_timeout,
    input  logic [NSTAT*8-1:0] cfg_static_addr,
    output logic               req_valid,
    input  logic               req_ready,
    output logic               req_kind,
    output logic [7:0]         req_addr,
    output logic [7:0]         req_ccc,
    output logic [7:0]         req_data,
    input  logic               rsp_valid,
    input  logic               rsp_ack,
    output logic               bus_hold_low,
    output logic               port_rst,
    output logic               mode_i3c,
    output logic               pullup_i3c,
    output logic               vio_low,
    output logic               done
);
    seq_state_e    st;
    bus_req_t      cur;
    logic          trig, go, fin, fin_ack, p1_ack;
    logic          t_load, t_exp;
    logic [CW-1:0] t_val;
    logic          s_clr, s_adv, s_last;
    logic [7:0]    s_addr;

    assign trig = redo_req | hotplug;

    // request fields follow the state, so they stay fixed for a whole transaction
    always_comb begin
        case (st)
            ST_DISC:   cur = mk_probe(s_addr);
            ST_ENABLE: cur = mk_ccc(CCC_HJ_ON);
            default:   cur = mk_ccc(CCC_HJ_OFF);
        endcase
    end

    assign req_kind = cur.kind;
    assign req_addr = cur.addr;
    assign req_ccc  = cur.ccc;
    assign req_data = cur.data;

    assign t_load = (st == ST_IDLE && trig && mode_i3c) || (st == ST_SWITCH && fin);
    assign t_val  = (st == ST_IDLE) ? cfg_t2wrst : cfg_tsmb2i3c;
    assign s_clr  = (st == ST_PROBE) && fin;
    assign s_adv  = (st == ST_DISC) && fin && !fin_ack && !s_last;

    assign bus_hold_low = (st == ST_RESET) && !cfg_rst_pin;
    assign port_rst     = (st == ST_RESET) && cfg_rst_pin;

    sbmode_xact #(.CW(CW)) u_xact (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .timeout   (cfg_timeout),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_ack   (rsp_ack),
        .fin       (fin),
        .fin_ack   (fin_ack)
    );

    sbmode_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (t_load),
        .val     (t_val),
        .expired (t_exp)
    );

    sbmode_scan #(.NSTAT(NSTAT)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .clr     (s_clr),
        .adv     (s_adv),
        .use_arp (cfg_use_arp),
        .list    (cfg_static_addr),
        .addr    (s_addr),
        .last    (s_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            go         <= 1'b0;
            done       <= 1'b0;
            p1_ack     <= 1'b0;
            mode_i3c   <= 1'b0;
            pullup_i3c <= 1'b0;
            vio_low    <= 1'b0;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            case (st)
                ST_IDLE: if (trig) begin
                    if (mode_i3c) begin
                        st <= ST_RESET;
                    end else begin
                        st <= ST_PROBE;
                        go <= 1'b1;
                    end
                end
                ST_RESET: if (t_exp) begin
                    pullup_i3c <= 1'b0;
                    vio_low    <= 1'b0;
                    mode_i3c   <= 1'b0;
                    st         <= ST_PROBE;
                    go         <= 1'b1;
                end
                ST_PROBE: if (fin) begin
                    p1_ack <= fin_ack;
                    st     <= ST_DISC;
                    go     <= 1'b1;
                end
                ST_DISC: if (fin) begin
                    if (fin_ack || (s_last && !p1_ack)) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else if (s_last) begin
                        st <= ST_SWITCH;
                        go <= 1'b1;
                    end else begin
                        go <= 1'b1;
                    end
                end
                ST_SWITCH: if (fin) begin
                    pullup_i3c <= 1'b1;
                    vio_low    <= 1'b1;
                    st         <= ST_SETTLE;
                end
                ST_SETTLE: if (t_exp) begin
                    mode_i3c <= 1'b1;
                    st       <= ST_ENABLE;
                    go       <= 1'b1;
                end
                ST_ENABLE: if (fin) begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sbmode_seq_chk.sv
module sbmode_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_kind,
    input logic [7:0] req_addr,
    input logic [7:0] req_ccc,
    input logic [7:0] req_data,
    input logic       bus_hold_low,
    input logic       port_rst,
    input logic       mode_i3c,
    input logic       pullup_i3c,
    input logic       vio_low,
    input logic       done
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_kind) && $stable(req_addr)
                                       && $stable(req_ccc) && $stable(req_data)));

    // R7
    rails_idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (pullup_i3c != $past(pullup_i3c)) |-> !req_valid);

    // R8
    mode_rails_chk: assert property (@(posedge clk) disable iff (rst)
        mode_i3c |-> (pullup_i3c && vio_low));

    // R9
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_hold_low || port_rst) |-> !req_valid);

    // R9
    hold_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_hold_low && port_rst));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid);
endmodule

bind sbmode_seq sbmode_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_kind     (req_kind),
    .req_addr     (req_addr),
    .req_ccc      (req_ccc),
    .req_data     (req_data),
    .bus_hold_low (bus_hold_low),
    .port_rst     (port_rst),
    .mode_i3c     (mode_i3c),
    .pullup_i3c   (pullup_i3c),
    .vio_low      (vio_low),
    .done         (done)
);

// File: tb/sbmode_seq_bench.sv
module sbmode_seq_bench;
    localparam int CW    = 16;
    localparam int NSTAT = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               redo_req = 1'b0;
    logic               hotplug = 1'b0;
    logic               cfg_use_arp = 1'b0;
    logic               cfg_rst_pin = 1'b0;
    logic [CW-1:0]      cfg_t2wrst = 16'd4;
    logic [CW-1:0]      cfg_tsmb2i3c = 16'd4;
    logic [CW-1:0]      cfg_timeout = 16'd20;
    logic [NSTAT*8-1:0] cfg_static_addr = {8'hA4, 8'h50, 8'h3A, 8'h20};
    logic               req_valid, req_ready = 1'b0, req_kind;
    logic [7:0]         req_addr, req_ccc, req_data;
    logic               rsp_valid = 1'b0, rsp_ack = 1'b0;
    logic               bus_hold_low, port_rst, mode_i3c, pullup_i3c, vio_low, done;

    sbmode_seq #(.CW(CW), .NSTAT(NSTAT)) u_sbmode_seq (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus engine model
    bit         bc_ack = 1'b1;
    logic [7:0] dev_addr = 8'h00;
    bit         silent = 1'b0;
    int         rdy_dly = 2, rsp_dly = 3;
    int         e_st = 0, e_cnt = 0;
    logic [24:0] e_cur;
    logic [24:0] log_q[$];
    logic [24:0] exp_q[$];

    always @(negedge clk) begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        if (rst) begin
            e_st = 0;
        end else begin
            case (e_st)
                0: if (req_valid) begin
                    e_cur = {req_kind, req_addr, req_ccc, req_data};
                    log_q.push_back(e_cur);
                    e_cnt = rdy_dly;
                    e_st = 1;
                end
                1: if (e_cnt == 0) begin
                    req_ready = 1'b1;
                    e_cnt = rsp_dly;
                    e_st = silent ? 0 : 2;
                end else e_cnt--;
                default: if (e_cnt == 0) begin
                    rsp_valid = 1'b1;
                    rsp_ack = (e_cur[24] == 1'b0) ? bc_ack
                            : (dev_addr != 8'h00 && e_cur[23:16] == dev_addr);
                    e_st = 0;
                end else e_cnt--;
            endcase
        end
    end

    // per-clock monitor and invariant comparison
    int cyc = 0, done_cnt = 0;
    int pu_rise = 0, pu_fall = 0, mode_rise = 0, hold_fall = 0, hold_len = 0;
    bit prev_pu = 0, prev_mode = 0, prev_hold = 0, saw_hold_low = 0, saw_port_rst = 0;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (!rst) begin
            chk(!mode_i3c || (pullup_i3c && vio_low), "R8 rails under I3C", mode_i3c, 0);
            chk(!(bus_hold_low || port_rst) || !req_valid, "R9 quiet hold", req_valid, 0);
            if (done) done_cnt++;
            if (pullup_i3c && !prev_pu) pu_rise = cyc;
            if (!pullup_i3c && prev_pu) pu_fall = cyc;
            if (mode_i3c && !prev_mode) mode_rise = cyc;
            if ((bus_hold_low || port_rst) && !prev_hold) hold_len = 0;
            if (bus_hold_low || port_rst) hold_len++;
            if (!(bus_hold_low || port_rst) && prev_hold) hold_fall = cyc;
            if (bus_hold_low) saw_hold_low = 1;
            if (port_rst) saw_port_rst = 1;
            prev_pu = pullup_i3c;
            prev_mode = mode_i3c;
            prev_hold = bus_hold_low || port_rst;
        end
    end

    task automatic push_ccc(input logic [7:0] code);
        exp_q.push_back({1'b0, 8'hFC, code, 8'h08});
    endtask

    task automatic push_probe(input logic [7:0] a);
        exp_q.push_back({1'b1, a, 8'h00, 8'h00});
    endtask

    task automatic run_pass(input bit use_hp);
        int d0;
        log_q.delete();
        saw_hold_low = 0;
        saw_port_rst = 0;
        d0 = done_cnt;
        @(negedge clk);
        if (use_hp) hotplug = 1'b1; else redo_req = 1'b1;
        @(negedge clk);
        hotplug = 1'b0;
        redo_req = 1'b0;
        for (int i = 0; i < 3000 && done_cnt == d0; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(done_cnt == d0 + 1, "R11 one done per pass", done_cnt - d0, 1);
    endtask

    task automatic cmp_log(input string tag);
        chk(log_q.size() == exp_q.size(), {tag, " request count"}, log_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
            chk(log_q[i] == exp_q[i], {tag, " request"}, int'(log_q[i]), int'(exp_q[i]));
        exp_q.delete();
    endtask

    task automatic chk_rails(input string tag, input int m, input int p, input int v);
        chk(mode_i3c == m, {tag, " mode_i3c"}, mode_i3c, m);
        chk(pullup_i3c == p, {tag, " pullup_i3c"}, pullup_i3c, p);
        chk(vio_low == v, {tag, " vio_low"}, vio_low, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_rails("R1", 0, 0, 0);
        chk(!bus_hold_low && !port_rst && !req_valid && !done, "R1 idle outputs",
            {bus_hold_low, port_rst, req_valid, done}, 0);

        // promotion to I3C via static scan, settle 5 (R2 R5 R7 R8)
        cfg_tsmb2i3c = 16'd5;
        run_pass(0);
        push_ccc(8'h01); push_probe(8'h20); push_probe(8'h3A); push_probe(8'h50); push_probe(8'hA4);
        push_ccc(8'h01); push_ccc(8'h00);
        cmp_log("R2 R5 R7 R8 promotion");
        chk_rails("R8 promoted", 1, 1, 1);
        chk(mode_rise - pu_rise == 5, "R8 settle cycles", mode_rise - pu_rise, 5);

        // hot-plug from I3C, clock hold 7, legacy device at second entry (R9 R5 R6)
        cfg_rst_pin = 1'b0; cfg_t2wrst = 16'd7; dev_addr = 8'h3A;
        run_pass(1);
        chk(hold_len == 7, "R9 hold length", hold_len, 7);
        chk(saw_hold_low && !saw_port_rst, "R9 hold line select", {saw_hold_low, saw_port_rst}, 2);
        chk(pu_fall == hold_fall, "R9 rails drop with hold end", pu_fall, hold_fall);
        push_ccc(8'h01); push_probe(8'h20); push_probe(8'h3A);
        cmp_log("R5 R6 stop at first ack");
        chk_rails("R6 stays SMBus", 0, 0, 0);

        // NACK on broadcast, ARP scan (R4)
        bc_ack = 1'b0; dev_addr = 8'h00; cfg_use_arp = 1'b1;
        run_pass(0);
        push_ccc(8'h01); push_probe(8'hC2);
        cmp_log("R4 nack path");
        chk(!saw_hold_low && !saw_port_rst, "R4 no hold from SMBus", saw_hold_low, 0);
        chk_rails("R4 SMBus", 0, 0, 0);

        // silent engine: timeout counts as NACK (R3)
        silent = 1'b1; bc_ack = 1'b1; cfg_timeout = 16'd4;
        run_pass(0);
        push_ccc(8'h01); push_probe(8'hC2);
        cmp_log("R3 timeout");
        chk_rails("R3 timeout SMBus", 0, 0, 0);

        // response in last window cycle, settle 0 (R3 R8)
        silent = 1'b0; cfg_timeout = 16'd6; rsp_dly = 5; cfg_tsmb2i3c = 16'd0;
        run_pass(0);
        push_ccc(8'h01); push_probe(8'hC2); push_ccc(8'h01); push_ccc(8'h00);
        cmp_log("R3 last window cycle");
        chk_rails("R3 promoted", 1, 1, 1);
        chk(mode_rise - pu_rise == 1, "R8 settle minimum", mode_rise - pu_rise, 1);

        // return via dedicated reset, length 0 (R9)
        cfg_rst_pin = 1'b1; cfg_t2wrst = 16'd0; bc_ack = 1'b0; rsp_dly = 3;
        run_pass(0);
        chk(hold_len == 1, "R9 reset pin minimum", hold_len, 1);
        chk(saw_port_rst && !saw_hold_low, "R9 reset pin select", {saw_hold_low, saw_port_rst}, 1);
        push_ccc(8'h01); push_probe(8'hC2);
        cmp_log("R9 restart");
        chk_rails("R9 back to SMBus", 0, 0, 0);

        // triggers mid-pass are ignored (R10)
        cfg_use_arp = 1'b0; bc_ack = 1'b1; dev_addr = 8'h50;
        fork
            run_pass(0);
            begin
                wait (log_q.size() >= 2);
                @(negedge clk); hotplug = 1'b1;
                @(negedge clk); hotplug = 1'b0;
                @(negedge clk); redo_req = 1'b1;
                @(negedge clk); redo_req = 1'b0;
            end
        join
        push_ccc(8'h01); push_probe(8'h20); push_probe(8'h3A); push_probe(8'h50);
        cmp_log("R10 ignored triggers");
        chk_rails("R10 outcome", 0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule